// File: doc/BRIEF.md
# Byte-Synchronous Transmit Framer with Block Check

This block is the transmit half of a byte-oriented synchronous line framer. A frame begins when a byte marked as start-of-frame is offered while the block is idle. The block then sends a preamble of two-character sync patterns. It takes data characters from a valid/ready byte stream and shifts them out least significant bit first, one bit for each pulse of a bit-clock enable. After the character marked end-of-frame it appends a block check and returns to an idle mark level.

The block check is either a 16-bit CRC or a one-character longitudinal sum (XOR) check. The check mode is chosen by a two-bit configuration field. In sum-check mode, and only when the frame is not transparent, each character can carry a parity bit in its top bit position. The framer latches its whole configuration at the start of each frame, so software may change it while a frame is on the line. If the source cannot supply a character when one is due, the framer sends a sync pair as line fill and tries again at the next character slot.

Top module: `bsync_tx_framer`

## Requirements
- R1: Out of reset and between frames `tx_active` is 0 and `tx_bit` is held at 1 (mark).
- R2: While idle, `in_valid`=1 with `in_sof`=1 starts a frame without consuming that byte. `tx_active` rises on the next cycle. The preamble is `cfg_sync_cnt`+1 pairs, each pair `cfg_sync1` followed by `cfg_sync2`, and both characters of a pair are always sent.
- R3: Every character is sent LSB first, one bit for each cycle with `bit_en`=1. `in_ready` is 1 during an active frame only in the cycle that has `bit_en` while the last bit of a character is on the line and the next slot is a data character. A byte is taken when `in_valid` is also 1 in that cycle.
- R4: `cfg_chk_mode` values 00, 01 and 10 select CRC-16 with polynomial x^16+x^15+x^2+1, shifted LSB first (reflected constant 0xA001). The register is preset to 0x0000 when `cfg_chk_preset`=0 and to 0xFFFF when it is 1. The CRC covers data characters only and is sent uninverted, low byte first.
- R5: `cfg_chk_mode`=11 with `cfg_transp`=0 selects the sum check. It is the XOR of all sent data characters (parity bit included), preset to 0x00 when `cfg_chk_preset`=0 or to 0xFF when it is 1, and it is sent as one character.
- R6: In sum-check mode with `cfg_par_en`=1, bit 7 of each data character is replaced by a parity bit over bits 6..0. The parity is even when `cfg_par_odd`=0 and odd when it is 1. In all other cases the 8 bits are sent unchanged.
- R7: With `cfg_transp`=1 the framer uses CRC-16 and plain 8-bit characters whatever `cfg_chk_mode` and `cfg_par_en` hold.
- R8: If `in_valid` is 0 at a data slot, a fill pair (`cfg_sync1`, `cfg_sync2`) is sent and left out of the check, and the next data slot follows that pair.
- R9: After the character marked `in_eof`, the check characters follow at once and the block is idle on the cycle after the `bit_en` of their last bit. The next frame may then start.
- R10: While idle, a byte offered without `in_sof` is accepted (`in_ready`=1) and discarded, and the line stays at mark.
- R11: All configuration inputs are sampled in the start cycle of a frame, and changes during the frame take effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable: one line bit per pulse |
| cfg_sync_cnt | input | 4 | Sync pairs in preamble, minus one |
| cfg_chk_mode | input | 2 | Check select: 11 sum check, others CRC-16 |
| cfg_chk_preset | input | 1 | Check register preset: 0 all zeros, 1 all ones |
| cfg_par_en | input | 1 | Parity on characters in sum-check mode |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_transp | input | 1 | Transparent frame: CRC-16, 8-bit characters |
| cfg_sync1 | input | 8 | First sync character |
| cfg_sync2 | input | 8 | Second sync character |
| in_valid | input | 1 | Byte offered |
| in_sof | input | 1 | Offered byte starts a frame |
| in_eof | input | 1 | Offered byte ends a frame |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| tx_bit | output | 1 | Serial line output |
| tx_active | output | 1 | Frame in progress |

## Verification
A start request shows on `tx_active` one cycle later, and bit 0 of the first sync character is on `tx_bit` in that same cycle. Every later bit replaces the previous one on the cycle after a `bit_en`. `in_ready` is combinational and is due in the very cycle whose `bit_en` ends a character, and the line returns to idle one cycle after the final check bit's enable. The bench drives inputs at the falling edge, waits one time unit and then compares `tx_active`, `in_ready` and, in each enabled cycle, `tx_bit` against a queue of expected line bits. That queue is built from the byte stream and the configuration captured at frame start, so every check falls in the cycle the design's registers make the result visible.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_DATA  = 2'd2,
        ST_CHECK = 2'd3
    } tx_state_e;

    localparam logic [1:0] CHK_MODE_SUM = 2'b11;

endpackage

// File: rtl/bsync_char_fmt.sv
module bsync_char_fmt #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] raw,
    input  logic              par_on,
    input  logic              par_odd,
    output logic [CHAR_W-1:0] fmt
);
    logic par_bit;

    always_comb begin
        par_bit = (^raw[CHAR_W-2:0]) ^ par_odd;
        fmt     = par_on ? {par_bit, raw[CHAR_W-2:0]} : raw;
    end
endmodule

// File: rtl/bsync_chk_next.sv
module bsync_chk_next #(
    parameter int                  CHAR_W   = 8,
    parameter logic [2*CHAR_W-1:0] CRC_POLY = 16'hA001
) (
    input  logic [2*CHAR_W-1:0] chk_in,
    input  logic [CHAR_W-1:0]   char_in,
    input  logic                sum_mode,
    output logic [2*CHAR_W-1:0] chk_out
);
    localparam int CHK_W = 2 * CHAR_W;

    logic [CHK_W-1:0] stage [0:CHAR_W];
    logic [CHK_W-1:0] sum_v;

    assign stage[0] = chk_in;

    for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
        logic fb;
        assign fb           = stage[i][0] ^ char_in[i];
        assign stage[i + 1] = (stage[i] >> 1) ^ (fb ? CRC_POLY : '0);
    end

    assign sum_v   = {chk_in[CHK_W-1:CHAR_W], chk_in[CHAR_W-1:0] ^ char_in};
    assign chk_out = sum_mode ? sum_v : stage[CHAR_W];
endmodule

// File: rtl/bsync_bit_shifter.sv
module bsync_bit_shifter #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_val,
    input  logic              step,
    output logic              bit_out,
    output logic              last
);
    localparam int               IDX_W = $clog2(CHAR_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_W - 1);

    logic [CHAR_W-1:0] sh_d, sh_q;
    logic [IDX_W-1:0]  idx_d, idx_q;

    always_comb begin
        sh_d  = sh_q;
        idx_d = idx_q;
        if (load) begin
            sh_d  = load_val;
            idx_d = '0;
        end else if (step) begin
            sh_d  = {1'b1, sh_q[CHAR_W-1:1]};
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '1;
            idx_q <= '0;
        end else begin
            sh_q  <= sh_d;
            idx_q <= idx_d;
        end
    end

    assign bit_out = sh_q[0];
    assign last    = (idx_q == LAST_IDX);
endmodule

// File: rtl/bsync_tx_framer.sv
module bsync_tx_framer
    import bsync_pkg::*;
#(
    parameter int                  CHAR_W   = 8,
    parameter int                  CNT_W    = 4,
    parameter logic [2*CHAR_W-1:0] CRC_POLY = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [CNT_W-1:0]  cfg_sync_cnt,
    input  logic [1:0]        cfg_chk_mode,
    input  logic              cfg_chk_preset,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_transp,
    input  logic [CHAR_W-1:0] cfg_sync1,
    input  logic [CHAR_W-1:0] cfg_sync2,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              tx_active
);
    localparam int CHK_W = 2 * CHAR_W;

    typedef struct packed {
        tx_state_e         st;
        logic              sel;
        logic              fill;
        logic              eof_pend;
        logic              hi_sent;
        logic [CNT_W-1:0]  left;
        logic [CHK_W-1:0]  chk;
        logic              sum_mode;
        logic              par_on;
        logic              par_odd;
        logic [CHAR_W-1:0] syn1;
        logic [CHAR_W-1:0] syn2;
    } regs_t;

    regs_t q, d;

    logic              active;
    logic              ser_bit, ser_last;
    logic              load;
    logic [CHAR_W-1:0] load_val;
    logic              boundary, fetch;
    logic [CHAR_W-1:0] fmt_char;
    logic [CHK_W-1:0]  chk_upd;
    logic              cfg_sum;

    assign active   = (q.st != ST_IDLE);
    assign boundary = bit_en && ser_last && active;
    assign fetch    = boundary &&
                      (((q.st == ST_SYNC) && q.sel && (q.fill || (q.left == '0))) ||
                       ((q.st == ST_DATA) && !q.eof_pend));
    assign cfg_sum  = (cfg_chk_mode == CHK_MODE_SUM) && !cfg_transp;

    bsync_char_fmt #(.CHAR_W(CHAR_W)) u_fmt (
        .raw     (in_data),
        .par_on  (q.par_on),
        .par_odd (q.par_odd),
        .fmt     (fmt_char)
    );

    bsync_chk_next #(.CHAR_W(CHAR_W), .CRC_POLY(CRC_POLY)) u_chk (
        .chk_in   (q.chk),
        .char_in  (fmt_char),
        .sum_mode (q.sum_mode),
        .chk_out  (chk_upd)
    );

    always_comb begin
        d        = q;
        load     = 1'b0;
        load_val = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    d.st       = ST_SYNC;
                    d.sel      = 1'b0;
                    d.fill     = 1'b0;
                    d.eof_pend = 1'b0;
                    d.hi_sent  = 1'b0;
                    d.left     = cfg_sync_cnt;
                    d.chk      = {CHK_W{cfg_chk_preset}};
                    d.sum_mode = cfg_sum;
                    d.par_on   = cfg_sum && cfg_par_en;
                    d.par_odd  = cfg_par_odd;
                    d.syn1     = cfg_sync1;
                    d.syn2     = cfg_sync2;
                    load       = 1'b1;
                    load_val   = cfg_sync1;
                end
            end
            ST_SYNC: begin
                if (boundary && !q.sel) begin
                    d.sel    = 1'b1;
                    load     = 1'b1;
                    load_val = q.syn2;
                end else if (boundary && !fetch) begin
                    d.sel    = 1'b0;
                    d.left   = q.left - CNT_W'(1);
                    load     = 1'b1;
                    load_val = q.syn1;
                end
            end
            ST_DATA: begin
                if (boundary && q.eof_pend) begin
                    d.st      = ST_CHECK;
                    d.hi_sent = 1'b0;
                    load      = 1'b1;
                    load_val  = q.chk[CHAR_W-1:0];
                end
            end
            ST_CHECK: begin
                if (boundary) begin
                    if (!q.sum_mode && !q.hi_sent) begin
                        d.hi_sent = 1'b1;
                        load      = 1'b1;
                        load_val  = q.chk[CHK_W-1:CHAR_W];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fetch) begin
            load = 1'b1;
            if (in_valid) begin
                d.st       = ST_DATA;
                d.chk      = chk_upd;
                d.eof_pend = in_eof;
                load_val   = fmt_char;
            end else begin
                d.st     = ST_SYNC;
                d.sel    = 1'b0;
                d.fill   = 1'b1;
                load_val = q.syn1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    bsync_bit_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .step     (bit_en && active && !load),
        .bit_out  (ser_bit),
        .last     (ser_last)
    );

    assign in_ready  = active ? fetch : !in_sof;
    assign tx_bit    = active ? ser_bit : 1'b1;
    assign tx_active = active;
endmodule

// File: rtl/bsync_tx_framer_sva.sv
module bsync_tx_framer_sva #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_ready,
    input logic              tx_bit,
    input logic              tx_active,
    input logic [CHAR_W-1:0] cfg_sync1
);
    // R1: mark level whenever no frame is running
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_bit);

    // R2: a start request while idle opens a frame on the next cycle
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && in_valid && in_sof) |=> tx_active);

    // R2: first line bit is bit 0 of the first sync character
    p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> (tx_bit == $past(cfg_sync1[0])));

    // R3: during a frame a byte is only taken on an enabled bit
    p_ready_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && in_ready) |-> bit_en);

    // R3: the line holds its bit between enables
    p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !bit_en) |=> (tx_active && (tx_bit == $past(tx_bit))));

    // R10: idle bytes without a start mark are accepted
    p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && in_valid && !in_sof) |-> in_ready);
endmodule

bind bsync_tx_framer bsync_tx_framer_sva #(.CHAR_W(CHAR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_ready  (in_ready),
    .tx_bit    (tx_bit),
    .tx_active (tx_active),
    .cfg_sync1 (cfg_sync1)
);

// File: tb/sim_bsync_tx_framer.sv
module sim_bsync_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] cfg_sync_cnt = '0;
    logic [1:0] cfg_chk_mode = 2'b01;
    logic       cfg_chk_preset = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_transp = 1'b0;
    logic [7:0] cfg_sync1 = 8'h16, cfg_sync2 = 8'h32;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, tx_bit, tx_active;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsync_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .cfg_sync_cnt(cfg_sync_cnt), .cfg_chk_mode(cfg_chk_mode),
        .cfg_chk_preset(cfg_chk_preset), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_transp(cfg_transp),
        .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .tx_bit(tx_bit), .tx_active(tx_active)
    );

    typedef struct {
        logic [7:0] d;
        bit         sof;
        bit         eof;
        int         gap;
    } item_t;

    item_t      src_q[$];
    bit         exp_q[$];
    int         n_cmp = 0, n_bad = 0, cyc = 0, div = 1;
    bit         in_frame = 0;
    bit         m_sum, m_par_on, m_par_odd;
    logic [7:0] m_s1, m_s2;
    logic [15:0] m_chk;
    string      cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_sim();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic void push_char(input logic [7:0] c);
        for (int i = 0; i < 8; i++) exp_q.push_back(c[i]);
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] ch);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ ch[i]) r = (r >> 1) ^ 16'hA001;
            else              r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] fmt_char(input logic [7:0] r);
        if (m_par_on) return {(^r[6:0]) ^ m_par_odd, r[6:0]};
        return r;
    endfunction

    // one clock of stimulus plus the reference comparison
    task automatic cycle();
        bit q_empty_pre, popped_last, exp_ready, b;
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
            finish_sim();
        end
        bit_en = ((cyc % div) == 0);
        if (src_q.size() > 0 && src_q[0].gap > 0) begin
            src_q[0].gap = src_q[0].gap - 1;
            in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
        end else if (src_q.size() > 0) begin
            in_valid = 1; in_sof = src_q[0].sof; in_eof = src_q[0].eof; in_data = src_q[0].d;
        end else begin
            in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
        end
        #1;
        if (!rst_n) return;
        q_empty_pre = (exp_q.size() == 0);
        check(tx_active == !q_empty_pre, "R1 tx_active", tx_active, !q_empty_pre);
        if (!tx_active) check(tx_bit == 1'b1, "R1 idle mark", tx_bit, 1);
        popped_last = 0;
        if (bit_en && !q_empty_pre) begin
            b = exp_q.pop_front();
            check(tx_bit == b, {cur_tag, " line bit"}, tx_bit, b);
            if (exp_q.size() == 0) popped_last = 1;
        end
        exp_ready = q_empty_pre ? !in_sof : (in_frame && popped_last);
        check(in_ready == exp_ready, q_empty_pre ? "R10 in_ready idle" : "R3 in_ready", in_ready, exp_ready);

        if (q_empty_pre && in_valid && in_sof) begin
            m_sum     = (cfg_chk_mode == 2'b11) && !cfg_transp;
            m_par_on  = m_sum && cfg_par_en;
            m_par_odd = cfg_par_odd;
            m_s1 = cfg_sync1; m_s2 = cfg_sync2;
            m_chk = {16{cfg_chk_preset}};
            for (int p = 0; p <= int'(cfg_sync_cnt); p++) begin
                push_char(m_s1); push_char(m_s2);
            end
            in_frame = 1;
        end else if (in_frame && popped_last) begin
            if (in_valid) begin
                logic [7:0] c;
                c = fmt_char(in_data);
                push_char(c);
                if (m_sum) m_chk[7:0] = m_chk[7:0] ^ c;
                else       m_chk = crc_step(m_chk, c);
                if (in_eof) begin
                    in_frame = 0;
                    push_char(m_chk[7:0]);
                    if (!m_sum) push_char(m_chk[15:8]);
                end
            end else begin
                push_char(m_s1); push_char(m_s2);
            end
        end
        if (in_valid && exp_ready && src_q.size() > 0) void'(src_q.pop_front());
    endtask

    task automatic add_item(input logic [7:0] d, input bit sof, input bit eof, input int gap);
        item_t it;
        it.d = d; it.sof = sof; it.eof = eof; it.gap = gap;
        src_q.push_back(it);
    endtask

    task automatic add_frame(input int n, input logic [7:0] seed, input int gap_every);
        for (int i = 0; i < n; i++)
            add_item(seed + 8'(i * 37), i == 0, i == n - 1,
                     (gap_every > 0 && (i % gap_every) == gap_every - 1) ? 40 : 0);
    endtask

    task automatic run_done();
        while (src_q.size() > 0 || exp_q.size() > 0 || in_frame) cycle();
        repeat (4) cycle();
    endtask

    task automatic set_cfg(input logic [3:0] cnt, input logic [1:0] mode, input bit pre,
                           input bit pen, input bit podd, input bit tr);
        cfg_sync_cnt = cnt; cfg_chk_mode = mode; cfg_chk_preset = pre;
        cfg_par_en = pen; cfg_par_odd = podd; cfg_transp = tr;
    endtask

    initial begin
        repeat (3) cycle();
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        repeat (3) cycle();
        check(tx_active == 1'b0 && tx_bit == 1'b1, "R1 after reset", {tx_active, tx_bit}, 2'b01);

        // R4: reference CRC of "123456789" with zero preset
        begin
            logic [15:0] c = 16'h0000;
            for (int i = 0; i < 9; i++) c = crc_step(c, 8'h31 + 8'(i));
            check(c == 16'hBB3D, "R4 crc reference", c, 16'hBB3D);
        end

        // R4 R9: CRC frame, one sync pair, bit every cycle
        cur_tag = "R4 R9"; div = 1;
        set_cfg(4'd0, 2'b01, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) add_item(8'h31 + 8'(i), i == 0, i == 8, 0);
        run_done();

        // R2 R8: sixteen pairs, ones preset, slow bit clock, source gaps
        cur_tag = "R2 R8"; div = 3;
        set_cfg(4'd15, 2'b01, 1, 0, 0, 0);
        add_frame(5, 8'hA5, 2);
        run_done();

        // R5 R6: sum check, even parity, zero preset
        cur_tag = "R5 R6 even"; div = 2;
        set_cfg(4'd2, 2'b11, 0, 1, 0, 0);
        add_frame(6, 8'h4C, 0);
        run_done();

        // R5 R6: sum check, odd parity, ones preset
        cur_tag = "R5 R6 odd"; div = 1;
        set_cfg(4'd1, 2'b11, 1, 1, 1, 0);
        add_frame(7, 8'hF3, 3);
        run_done();

        // R5: sum check without parity keeps 8 bits
        cur_tag = "R5 R6 nopar";
        set_cfg(4'd0, 2'b11, 0, 0, 0, 0);
        add_frame(4, 8'h81, 0);
        run_done();

        // R7: transparent overrides sum check and parity
        cur_tag = "R7";
        set_cfg(4'd3, 2'b11, 0, 1, 1, 1);
        add_frame(5, 8'hE0, 0);
        run_done();

        // R4: reserved codes behave as CRC-16
        cur_tag = "R4 mode00";
        set_cfg(4'd0, 2'b00, 1, 1, 0, 0);
        add_frame(3, 8'h5A, 0);
        run_done();
        cur_tag = "R4 mode10";
        set_cfg(4'd1, 2'b10, 0, 1, 0, 0);
        add_frame(3, 8'hC3, 0);
        run_done();

        // R10: stray idle bytes are dropped
        cur_tag = "R10";
        add_item(8'h77, 0, 0, 0);
        add_item(8'h78, 0, 1, 0);
        run_done();
        check(tx_active == 1'b0 && tx_bit == 1'b1, "R10 line stays idle", {tx_active, tx_bit}, 2'b01);

        // R11 R9: config changed mid-frame, back-to-back frames
        cur_tag = "R11 R9"; div = 2;
        cfg_sync1 = 8'h3C; cfg_sync2 = 8'hA9;
        set_cfg(4'd1, 2'b01, 0, 0, 0, 0);
        add_frame(4, 8'h10, 0);
        add_frame(3, 8'h90, 0);
        while (!tx_active) cycle();
        set_cfg(4'd5, 2'b11, 1, 1, 1, 0);
        cfg_sync1 = 8'h55; cfg_sync2 = 8'h0F;
        run_done();

        finish_sim();
    end
endmodule